// File: doc/BRIEF.md
# Decode-Resolved Branch Fetch Controller

This block owns the fetch program counter and the fetch/decode pipeline register control for a five-stage in-order pipeline. Conditional branches and jumps are settled in the decode stage. An equality comparator and a target adder work on the decoded instruction, so a redirect is known one cycle after the branch was fetched. By then exactly one more instruction, the one at the next sequential address, has already been fetched.

A mode input picks what happens to that instruction. In delayed mode it always runs as a delay slot, and the redirect applies to the fetch after it. In squash mode a taken branch or jump replaces it with a bubble, so a taken transfer costs two cycles.

A stall input from the hazard unit freezes everything. A branch held in decode redirects only once the stall drops. Past decode, a resolved branch carries no further work and passes the later stages as an idle instruction; those stages are outside this block.

Top module: `dbc_fetch_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the following hold: `fetch_pc_o` equals `RESET_PC`, `dec_valid_o` is 0, and `redirect_o` and `squash_o` are 0.
- R2: With no stall and no redirect, `next_pc_o` is `fetch_pc_o + 4`. On the next edge the fetch PC takes that value and `dec_pc_o` takes the old fetch PC.
- R3: The 2-bit `dec_kind_i` code is 00 for other, 01 for branch-if-equal, 10 for branch-if-not-equal and 11 for jump. An equal-branch is taken when `dec_opa_i == dec_opb_i`, and a not-equal-branch is taken when they differ. The decision and `redirect_o` appear in the same cycle the branch is in decode.
- R4: A taken branch sets `next_pc_o` to `(dec_pc_o + 4) + (sign-extended dec_off_i << 2)`.
- R5: A jump is always taken. Its target is bits 31:28 of `dec_pc_o + 4`, followed by `dec_jidx_i`, followed by two zero bits.
- R6: When `delayed_mode_i` is 1, the instruction fetched right after a branch or jump enters decode valid, whether or not the transfer is taken.
- R7: When `delayed_mode_i` is 0, a taken transfer raises `squash_o`, and the next decode slot is a bubble (`dec_valid_o` = 0). A not-taken branch inserts no bubble.
- R8: A bubble in decode (`dec_valid_o` = 0) never redirects, whatever `dec_kind_i` shows.
- R9: While `stall_i` is 1, `redirect_o` is 0, `next_pc_o` equals `fetch_pc_o`, and the fetch and decode PCs hold. A branch held in decode redirects in the first cycle after the stall drops.
- R10: In delayed mode, a branch or jump sitting in a delay slot is treated as an ordinary instruction and does not redirect. In squash mode, a branch that follows a not-taken branch is resolved normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hazard-unit stall; freezes PC and fetch/decode register |
| delayed_mode_i | input | 1 | 1 = delay-slot semantics, 0 = squash wrong-path instruction |
| dec_kind_i | input | 2 | Decoded control class of the decode-stage instruction |
| dec_opa_i | input | XLEN | First register operand |
| dec_opb_i | input | XLEN | Second register operand |
| dec_off_i | input | 16 | Signed branch word offset |
| dec_jidx_i | input | 26 | Jump word index |
| fetch_pc_o | output | XLEN | Address being fetched this cycle |
| next_pc_o | output | XLEN | Address to fetch next cycle |
| redirect_o | output | 1 | Control transfer taken this cycle |
| squash_o | output | 1 | Replace the fetched instruction with a bubble |
| dec_valid_o | output | 1 | Decode stage holds a real instruction |
| dec_pc_o | output | XLEN | Address of the decode-stage instruction |

## Verification
Faults in the state show up at the ports within one to two cycles:
- A corrupted fetch PC appears at once on `fetch_pc_o`, and one edge later on `dec_pc_o`.
- A wrong delay-slot marker shows up as a redirect issued from a delay slot, or as a redirect that is missing after a not-taken squash-mode branch. Either one changes `next_pc_o` in that same cycle.
- A lost bubble marker is visible on `dec_valid_o` on the edge right after the squash.

The bench follows the executed-address trace through `dec_pc_o` and `dec_valid_o` in both modes, so each of these faults shows up on the port it reaches.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    typedef enum logic [1:0] {
        K_OTHER = 2'b00,
        K_BEQ   = 2'b01,
        K_BNE   = 2'b10,
        K_JUMP  = 2'b11
    } kind_e;

    localparam int OFF_W  = 16;
    localparam int JIDX_W = 26;
endpackage

// File: rtl/dbc_resolve.sv
module dbc_resolve
    import dbc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int LANE = 8
) (
    input  kind_e            kind,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic             is_ctl,
    output logic             taken
);
    localparam int NLANE = XLEN / LANE;

    logic [NLANE-1:0] lane_eq;
    logic             eq;

    // Split equality into lanes so the compare reduces as a shallow AND tree.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_eq[g] = (opa[g*LANE +: LANE] == opb[g*LANE +: LANE]);
    end

    always_comb begin
        eq     = &lane_eq;
        is_ctl = (kind != K_OTHER);
        unique case (kind)
            K_BEQ:   taken = eq;
            K_BNE:   taken = !eq;
            K_JUMP:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbc_target.sv
module dbc_target #(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   slot_pc,
    input  logic [OFF_W-1:0]  off,
    input  logic [JIDX_W-1:0] jidx,
    input  logic              is_jump,
    output logic [XLEN-1:0]   target
);
    localparam int HI_W = XLEN - JIDX_W - 2;

    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;

    always_comb begin
        off_ext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
        br_tgt  = slot_pc + (off_ext << 2);
        jmp_tgt = {slot_pc[XLEN-1 -: HI_W], jidx, 2'b00};
        target  = is_jump ? jmp_tgt : br_tgt;
    end
endmodule

// File: rtl/dbc_fetch_ctrl.sv
module dbc_fetch_ctrl
    import dbc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CMP_LANE = 8,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              delayed_mode_i,
    input  logic [1:0]        dec_kind_i,
    input  logic [XLEN-1:0]   dec_opa_i,
    input  logic [XLEN-1:0]   dec_opb_i,
    input  logic [OFF_W-1:0]  dec_off_i,
    input  logic [JIDX_W-1:0] dec_jidx_i,
    output logic [XLEN-1:0]   fetch_pc_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              redirect_o,
    output logic              squash_o,
    output logic              dec_valid_o,
    output logic [XLEN-1:0]   dec_pc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] dec_pc;
        logic            dec_valid;
        logic            dec_slot;
    } state_t;

    state_t          st_d, st_q;
    kind_e           kind;
    logic            is_ctl, taken, live, redirect, squash;
    logic [XLEN-1:0] slot_pc, target, npc;

    assign kind    = kind_e'(dec_kind_i);
    assign slot_pc = st_q.dec_pc + STEP;

    dbc_resolve #(.XLEN(XLEN), .LANE(CMP_LANE)) u_resolve (
        .kind   (kind),
        .opa    (dec_opa_i),
        .opb    (dec_opb_i),
        .is_ctl (is_ctl),
        .taken  (taken)
    );

    dbc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_target (
        .slot_pc (slot_pc),
        .off     (dec_off_i),
        .jidx    (dec_jidx_i),
        .is_jump (kind == K_JUMP),
        .target  (target)
    );

    always_comb begin
        st_d     = st_q;
        // Only a real, non-slot instruction in decode may steer fetch.
        live     = st_q.dec_valid && !st_q.dec_slot;
        redirect = live && taken && !stall_i;
        squash   = redirect && !delayed_mode_i;
        if (stall_i)       npc = st_q.pc;
        else if (redirect) npc = target;
        else               npc = st_q.pc + STEP;
        if (!stall_i) begin
            st_d.pc        = npc;
            st_d.dec_pc    = st_q.pc;
            st_d.dec_valid = !squash;
            st_d.dec_slot  = live && is_ctl && delayed_mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc        <= RESET_PC;
            st_q.dec_pc    <= RESET_PC;
            st_q.dec_valid <= 1'b0;
            st_q.dec_slot  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc_o  = st_q.pc;
    assign next_pc_o   = npc;
    assign redirect_o  = redirect;
    assign squash_o    = squash;
    assign dec_valid_o = st_q.dec_valid;
    assign dec_pc_o    = st_q.dec_pc;
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall_i,
    input logic            delayed_mode_i,
    input logic [XLEN-1:0] fetch_pc_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            redirect_o,
    input logic            squash_o,
    input logic            dec_valid_o,
    input logic [XLEN-1:0] dec_pc_o
);
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !redirect_o) |=> (fetch_pc_o == $past(fetch_pc_o) + XLEN'(4)));

    p_fetch_to_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i |=> (dec_pc_o == $past(fetch_pc_o)));

    p_squash_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> (redirect_o && !delayed_mode_i));

    p_squash_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> !dec_valid_o);

    p_delay_slot_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && delayed_mode_i) |=> dec_valid_o);

    p_bubble_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> !redirect_o);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(fetch_pc_o) && $stable(dec_pc_o)));

    p_stall_no_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (!redirect_o && next_pc_o == fetch_pc_o));

    p_no_double_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);
endmodule

bind dbc_fetch_ctrl dbc_checker #(.XLEN(XLEN)) u_dbc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall_i        (stall_i),
    .delayed_mode_i (delayed_mode_i),
    .fetch_pc_o     (fetch_pc_o),
    .next_pc_o      (next_pc_o),
    .redirect_o     (redirect_o),
    .squash_o       (squash_o),
    .dec_valid_o    (dec_valid_o),
    .dec_pc_o       (dec_pc_o)
);

// File: tb/dbc_fetch_ctrl_tb.sv
module dbc_fetch_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int NVEC       = 15;

    typedef struct packed {
        logic        stl;
        logic        mode;
        logic [1:0]  kind;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] off;
        logic [7:0]  jidx;
        logic        red;
        logic        sq;
        logic        dv;
        logic [15:0] fpc;
        logic [15:0] dpc;
        logic [15:0] npc;
    } vec_t;

    // Kind codes: 0 other, 1 branch-equal, 2 branch-not-equal, 3 jump.
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b1,2'd1,8'h05,8'h05,16'h0000,8'h00,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0004}, // R8 bubble after reset
        '{1'b0,1'b1,2'd0,8'h00,8'h00,16'h0000,8'h00,1'b0,1'b0,1'b1,16'h0004,16'h0000,16'h0008}, // R2
        '{1'b0,1'b1,2'd1,8'h05,8'h05,16'h0004,8'h00,1'b1,1'b0,1'b1,16'h0008,16'h0004,16'h0018}, // R3 R4 taken
        '{1'b0,1'b1,2'd2,8'h01,8'h02,16'h0000,8'h00,1'b0,1'b0,1'b1,16'h0018,16'h0008,16'h001C}, // R6 R10 slot
        '{1'b0,1'b1,2'd2,8'h03,8'h03,16'h0000,8'h00,1'b0,1'b0,1'b1,16'h001C,16'h0018,16'h0020}, // R3 not taken
        '{1'b0,1'b1,2'd0,8'h00,8'h00,16'h0000,8'h00,1'b0,1'b0,1'b1,16'h0020,16'h001C,16'h0024}, // R6
        '{1'b0,1'b0,2'd2,8'h01,8'h02,16'hFFFC,8'h00,1'b1,1'b1,1'b1,16'h0024,16'h0020,16'h0014}, // R7 R4 negative
        '{1'b0,1'b0,2'd1,8'h07,8'h07,16'h0000,8'h00,1'b0,1'b0,1'b0,16'h0014,16'h0024,16'h0018}, // R7 R8 bubble
        '{1'b0,1'b0,2'd1,8'h01,8'h02,16'h0000,8'h00,1'b0,1'b0,1'b1,16'h0018,16'h0014,16'h001C}, // R7 no bubble
        '{1'b0,1'b0,2'd3,8'h00,8'h00,16'h0000,8'h40,1'b1,1'b1,1'b1,16'h001C,16'h0018,16'h0100}, // R5 R10
        '{1'b0,1'b0,2'd0,8'h00,8'h00,16'h0000,8'h00,1'b0,1'b0,1'b0,16'h0100,16'h001C,16'h0104}, // R7
        '{1'b1,1'b1,2'd1,8'h09,8'h09,16'h0002,8'h00,1'b0,1'b0,1'b1,16'h0104,16'h0100,16'h0104}, // R9 stall
        '{1'b0,1'b1,2'd1,8'h09,8'h09,16'h0002,8'h00,1'b1,1'b0,1'b1,16'h0104,16'h0100,16'h010C}, // R9 release
        '{1'b0,1'b1,2'd3,8'h00,8'h00,16'h0000,8'h55,1'b0,1'b0,1'b1,16'h010C,16'h0104,16'h0110}, // R10 slot jump
        '{1'b0,1'b1,2'd3,8'h00,8'h00,16'h0000,8'h03,1'b1,1'b0,1'b1,16'h0110,16'h010C,16'h000C}  // R5
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stall_i = 1'b0;
    logic            delayed_mode_i = 1'b1;
    logic [1:0]      dec_kind_i = '0;
    logic [XLEN-1:0] dec_opa_i = '0;
    logic [XLEN-1:0] dec_opb_i = '0;
    logic [15:0]     dec_off_i = '0;
    logic [25:0]     dec_jidx_i = '0;
    logic [XLEN-1:0] fetch_pc_o, next_pc_o, dec_pc_o;
    logic            redirect_o, squash_o, dec_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbc_fetch_ctrl #(.XLEN(XLEN)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall_i        (stall_i),
        .delayed_mode_i (delayed_mode_i),
        .dec_kind_i     (dec_kind_i),
        .dec_opa_i      (dec_opa_i),
        .dec_opb_i      (dec_opb_i),
        .dec_off_i      (dec_off_i),
        .dec_jidx_i     (dec_jidx_i),
        .fetch_pc_o     (fetch_pc_o),
        .next_pc_o      (next_pc_o),
        .redirect_o     (redirect_o),
        .squash_o       (squash_o),
        .dec_valid_o    (dec_valid_o),
        .dec_pc_o       (dec_pc_o)
    );

    task automatic chk(input string tag, input int row, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s row %0d: got %h expected %h", tag, row, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 fetch_pc", -1, fetch_pc_o, '0);
        chk("R1 dec_valid", -1, XLEN'(dec_valid_o), '0);
        chk("R1 redirect", -1, XLEN'(redirect_o), '0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            stall_i        = VEC[i].stl;
            delayed_mode_i = VEC[i].mode;
            dec_kind_i     = VEC[i].kind;
            dec_opa_i      = XLEN'(VEC[i].a);
            dec_opb_i      = XLEN'(VEC[i].b);
            dec_off_i      = VEC[i].off;
            dec_jidx_i     = 26'(VEC[i].jidx);
            @(negedge clk);
            chk("R2 fetch_pc", i, fetch_pc_o, XLEN'(VEC[i].fpc));
            chk("R6 dec_pc trace", i, dec_pc_o, XLEN'(VEC[i].dpc));
            chk("R6 dec_valid", i, XLEN'(dec_valid_o), XLEN'(VEC[i].dv));
            chk("R3 redirect", i, XLEN'(redirect_o), XLEN'(VEC[i].red));
            chk("R7 squash", i, XLEN'(squash_o), XLEN'(VEC[i].sq));
            chk("R4 next_pc", i, next_pc_o, XLEN'(VEC[i].npc));
            @(posedge clk);
            #1;
        end

        // R5: after the last jump, fetch lands on its target and the slot is decoded
        @(negedge clk);
        chk("R5 fetch after jump", 99, fetch_pc_o, 32'h0000_000C);
        chk("R6 slot after jump", 99, dec_pc_o, 32'h0000_0110);

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run fetch_pc", 100, fetch_pc_o, '0);
        chk("R1 mid-run dec_valid", 100, XLEN'(dec_valid_o), '0);
        chk("R1 mid-run squash", 100, XLEN'(squash_o), '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule